// File: doc/BRIEF.md
# Buck-boost bridge gate sequencer

This block is the digital sequencer for a full-bridge, inductor-based converter that can step up or step down to feed a smart-card supply rail. It drives four gate groups that never conduct together: a charge pair that stores energy in the inductor, a transfer pair that delivers that energy to the rail, a clamp pair that shorts out leftover inductor current, and an output pull-down that empties the rail. Comparator results arrive as synchronous inputs. The peak-current comparator ends a charge phase. The output-regulated comparator stops transfer and starts clamping.

The controller alternates between charge and transfer. A charge phase lasts until the peak-current flag rises, or until a charge watchdog runs out. A watchdog expiry also raises a sticky overload flag. A transfer phase has a fixed length. If the output reaches its target during a transfer, the transfer stops at once and the clamp takes over for as long as the output stays regulated. When the selected level is zero or the card is missing, the pull-down holds the rail low. One all-off dead cycle separates every change from one gate group to another. The latched voltage code is passed on to the comparator reference, because the peak threshold depends on the level.

States: ST_DISCH (pull-down on), ST_DEAD (all gates off, one cycle, then the stored target), ST_CHARGE, ST_XFER, ST_CLAMP. Transitions:
- DISCH→CHARGE when the discharge condition clears.
- CHARGE→XFER on a peak flag or a watchdog expiry.
- XFER→CLAMP on the regulated flag.
- XFER→CHARGE at the end of the transfer time.
- CLAMP→CHARGE when the regulated flag drops.
- Any active state→DISCH on the discharge condition.

Every transition passes through ST_DEAD.

Top module: `bridge_gate_seq`

## Requirements
- R1: While reset is asserted, pd_gate is 1, chg_gate, xfer_gate and clamp_gate are 0, vref_sel is 00 and overload is 0.
- R2: While pwr_en is 1, vref_sel takes the value of vsel one clock later. While pwr_en is 0 it becomes 00 one clock later. The code meanings are 00 off, 01 1.8 V, 10 3.0 V and 11 5.0 V.
- R3: When vref_sel is 00 or card_in is 0, any conducting charge, transfer or clamp gate turns off at the next clock. At the clock after that, pd_gate turns on, and it stays on while the condition lasts.
- R4: When the discharge condition clears, the gates are all off for one cycle and then chg_gate turns on.
- R5: When ipk_hit is 1 during a charge cycle, all gates are off in the next cycle and xfer_gate is on in the cycle after.
- R6: xfer_gate stays on for exactly XFER_NS worth of clock cycles (20 cycles in the bench). While vout_ok stays 0, one dead cycle follows and then chg_gate turns on.
- R7: When vout_ok is 1 during any transfer cycle, including the last one, xfer_gate turns off at the next clock. After one dead cycle clamp_gate turns on and stays on while vout_ok is 1. When vout_ok falls, one dead cycle follows and then charge resumes.
- R8: Whenever the conducting gate group changes from one group to another, a cycle with all four gates off lies between the two.
- R9: A charge cycle that lasts WDOG_NS worth of clock cycles (100 in the bench) without ipk_hit is forced to end. A dead cycle and then a transfer follow, and overload becomes 1. If ipk_hit arrives in that last cycle, overload stays 0.
- R10: overload stays 1 while pwr_en is 1 and becomes 0 one clock after pwr_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_en | input | 1 | Power-on enable |
| vsel | input | 2 | Requested output level code |
| ipk_hit | input | 1 | Inductor peak-current comparator flag |
| vout_ok | input | 1 | Output-regulated comparator flag |
| card_in | input | 1 | Card present flag |
| chg_gate | output | 1 | Charge pair gate enable |
| xfer_gate | output | 1 | Transfer pair gate enable |
| clamp_gate | output | 1 | Inductor clamp pair gate enable |
| pd_gate | output | 1 | Output pull-down gate enable |
| vref_sel | output | 2 | Latched level code sent to the comparator reference |
| overload | output | 1 | Sticky charge-watchdog overload flag |

## Verification
Two events can land in the same cycle. The peak-current flag can arrive in the final cycle of the charge watchdog, and the regulated flag can arrive in the final cycle of a transfer. The bench raises ipk_hit exactly when the charge cycle has run 99 cycles of its 100-cycle limit, then checks that the bridge moves through a dead cycle into transfer with overload still 0. It also raises vout_ok in the twentieth transfer cycle and checks that the next active group is the clamp rather than a new charge. A collision between discharge and clamping is provoked by removing the card while clamping; the pull-down must win after one dead cycle.

// File: rtl/bgs_pkg.sv
`timescale 1ns/1ps
package bgs_pkg;
    typedef enum logic [2:0] {
        ST_DISCH,
        ST_DEAD,
        ST_CHARGE,
        ST_XFER,
        ST_CLAMP
    } seq_state_e;

    typedef enum logic [1:0] {
        LVL_OFF = 2'b00,
        LVL_1V8 = 2'b01,
        LVL_3V0 = 2'b10,
        LVL_5V0 = 2'b11
    } level_e;

    // Converts a duration in ns into a whole number of clock cycles (at least 1).
    function automatic int ns_to_cycles(input longint hz, input longint ns);
        longint c;
        c = ((hz / 1000) * ns) / 1000000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction
endpackage

// File: rtl/bgs_code_latch.sv
`timescale 1ns/1ps
module bgs_code_latch #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q
);
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_en) code_q <= '0;
        else                   code_q <= code_in;
    end
endmodule

// File: rtl/bgs_cycle_timer.sv
`timescale 1ns/1ps
module bgs_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/bgs_overload_flag.sv
`timescale 1ns/1ps
module bgs_overload_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) flag <= 1'b0;
        else if (set)      flag <= 1'b1;
    end
endmodule

// File: rtl/bridge_gate_seq.sv
`timescale 1ns/1ps
module bridge_gate_seq
    import bgs_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 200_000_000,
    parameter int unsigned XFER_NS = 900,
    parameter int unsigned WDOG_NS = 4_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_en,
    input  logic [1:0] vsel,
    input  logic       ipk_hit,
    input  logic       vout_ok,
    input  logic       card_in,
    output logic       chg_gate,
    output logic       xfer_gate,
    output logic       clamp_gate,
    output logic       pd_gate,
    output logic [1:0] vref_sel,
    output logic       overload
);
    localparam int XFER_CYC = ns_to_cycles(longint'(CLK_HZ), longint'(XFER_NS));
    localparam int WDOG_CYC = ns_to_cycles(longint'(CLK_HZ), longint'(WDOG_NS));
    localparam int MAX_CYC  = (WDOG_CYC > XFER_CYC) ? WDOG_CYC : XFER_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    seq_state_e       state_q, state_d, tgt_q, tgt_d;
    logic [CNT_W-1:0] cnt;
    logic             disc, wd_last, xf_last, run, wd_trip;

    bgs_code_latch #(.CODE_W(2)) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_en  (pwr_en),
        .code_in (vsel),
        .code_q  (vref_sel)
    );

    assign run = (state_q == ST_CHARGE) || (state_q == ST_XFER);

    bgs_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .cnt   (cnt)
    );

    assign disc    = (vref_sel == LVL_OFF) || !card_in;
    assign wd_last = (cnt == CNT_W'(WDOG_CYC - 1));
    assign xf_last = (cnt == CNT_W'(XFER_CYC - 1));
    assign wd_trip = (state_q == ST_CHARGE) && !disc && wd_last && !ipk_hit;

    bgs_overload_flag u_ovl (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wd_trip),
        .clr   (!pwr_en),
        .flag  (overload)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DISCH;
            tgt_q   <= ST_DISCH;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    // Next state: every move between gate groups goes through ST_DEAD
    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        unique case (state_q)
            ST_DISCH: begin
                if (!disc) begin
                    state_d = ST_DEAD;
                    tgt_d   = ST_CHARGE;
                end
            end
            ST_DEAD: begin
                state_d = tgt_q;
            end
            ST_CHARGE: begin
                if (disc) begin
                    state_d = ST_DEAD;
                    tgt_d   = ST_DISCH;
                end else if (ipk_hit || wd_last) begin
                    state_d = ST_DEAD;
                    tgt_d   = ST_XFER;
                end
            end
            ST_XFER: begin
                if (disc) begin
                    state_d = ST_DEAD;
                    tgt_d   = ST_DISCH;
                end else if (vout_ok) begin
                    state_d = ST_DEAD;
                    tgt_d   = ST_CLAMP;
                end else if (xf_last) begin
                    state_d = ST_DEAD;
                    tgt_d   = ST_CHARGE;
                end
            end
            ST_CLAMP: begin
                if (disc) begin
                    state_d = ST_DEAD;
                    tgt_d   = ST_DISCH;
                end else if (!vout_ok) begin
                    state_d = ST_DEAD;
                    tgt_d   = ST_CHARGE;
                end
            end
            default: begin
                state_d = ST_DISCH;
                tgt_d   = ST_DISCH;
            end
        endcase
    end

    // Gate outputs decoded from the state register
    always_comb begin
        chg_gate   = 1'b0;
        xfer_gate  = 1'b0;
        clamp_gate = 1'b0;
        pd_gate    = 1'b0;
        unique case (state_q)
            ST_DISCH:  pd_gate    = 1'b1;
            ST_DEAD:   ;
            ST_CHARGE: chg_gate   = 1'b1;
            ST_XFER:   xfer_gate  = 1'b1;
            ST_CLAMP:  clamp_gate = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/bgs_checker.sv
`timescale 1ns/1ps
module bgs_checker
    import bgs_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 200_000_000,
    parameter int unsigned XFER_NS = 900,
    parameter int unsigned WDOG_NS = 4_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_en,
    input logic       ipk_hit,
    input logic       vout_ok,
    input logic       card_in,
    input logic       chg_gate,
    input logic       xfer_gate,
    input logic       clamp_gate,
    input logic       pd_gate,
    input logic [1:0] vref_sel,
    input logic       overload
);
    localparam int XFER_CYC = ns_to_cycles(longint'(CLK_HZ), longint'(XFER_NS));
    localparam int WDOG_CYC = ns_to_cycles(longint'(CLK_HZ), longint'(WDOG_NS));
    localparam int MAX_CYC  = (WDOG_CYC > XFER_CYC) ? WDOG_CYC : XFER_CYC;
    localparam int RUN_W    = $clog2(MAX_CYC + 2);

    logic [3:0]       grp;
    logic [RUN_W-1:0] chg_run, xf_run;

    assign grp = {chg_gate, xfer_gate, clamp_gate, pd_gate};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_run <= '0;
            xf_run  <= '0;
        end else begin
            chg_run <= chg_gate  ? chg_run + 1'b1 : '0;
            xf_run  <= xfer_gate ? xf_run + 1'b1  : '0;
        end
    end

    // R8
    dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp != 4'b0000 && $past(grp) != 4'b0000) |-> (grp == $past(grp)));

    // R7
    clamp_on_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_gate && vout_ok) |=> (!xfer_gate && !chg_gate && !clamp_gate));

    // R5
    peak_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_gate && ipk_hit) |=> (!chg_gate && !xfer_gate));

    // R3
    disc_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_in && (chg_gate || xfer_gate || clamp_gate)) |=>
        !(chg_gate || xfer_gate || clamp_gate));

    // R10
    ovl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overload && pwr_en) |=> overload);

    // R2
    power_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> (!overload && vref_sel == 2'b00));

    // R9
    wdog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_run <= RUN_W'(WDOG_CYC));

    // R6
    xfer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xf_run <= RUN_W'(XFER_CYC));
endmodule

bind bridge_gate_seq bgs_checker #(
    .CLK_HZ  (CLK_HZ),
    .XFER_NS (XFER_NS),
    .WDOG_NS (WDOG_NS)
) chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_en     (pwr_en),
    .ipk_hit    (ipk_hit),
    .vout_ok    (vout_ok),
    .card_in    (card_in),
    .chg_gate   (chg_gate),
    .xfer_gate  (xfer_gate),
    .clamp_gate (clamp_gate),
    .pd_gate    (pd_gate),
    .vref_sel   (vref_sel),
    .overload   (overload)
);

// File: tb/bridge_gate_seq_test.sv
`timescale 1ns/1ps
module bridge_gate_seq_test;
    localparam int XFER = 20;   // 100 ns at 200 MHz
    localparam int WDOG = 100;  // 500 ns at 200 MHz

    logic       clk = 1'b0;
    logic       rst_n, pwr_en, ipk_hit, vout_ok, card_in;
    logic [1:0] vsel;
    logic       chg_gate, xfer_gate, clamp_gate, pd_gate, overload;
    logic [1:0] vref_sel;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    // gate nibble order {chg, xfer, clamp, pd}
    localparam logic [3:0] G_OFF = 4'b0000, G_CHG = 4'b1000, G_XF = 4'b0100,
                           G_CL = 4'b0010, G_PD = 4'b0001;

    // {pwr_en, vsel[1:0], card_in, exp_vref[1:0], exp_pd}
    localparam logic [6:0] VEC [8] = '{
        7'b1_01_1_01_0, 7'b1_10_1_10_0, 7'b1_11_1_11_0, 7'b1_11_0_11_1,
        7'b1_00_1_00_1, 7'b0_11_1_00_1, 7'b1_10_1_10_0, 7'b1_01_1_01_0
    };

    always #2.5 clk = ~clk;

    bridge_gate_seq #(.CLK_HZ(200_000_000), .XFER_NS(100), .WDOG_NS(500)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .vsel(vsel),
        .ipk_hit(ipk_hit), .vout_ok(vout_ok), .card_in(card_in),
        .chg_gate(chg_gate), .xfer_gate(xfer_gate), .clamp_gate(clamp_gate),
        .pd_gate(pd_gate), .vref_sel(vref_sel), .overload(overload)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] gates();
        return {chg_gate, xfer_gate, clamp_gate, pd_gate};
    endfunction

    // Leaves the bridge in its first charge cycle (timer count 0)
    task automatic enter_charge();
        pwr_en = 1'b0; ipk_hit = 1'b0; vout_ok = 1'b0; card_in = 1'b1;
        tick(4);
        chk("R3", "pd while off", gates(), G_PD);
        pwr_en = 1'b1; vsel = 2'b01;
        tick(3);
        chk("R4", "charge after start", gates(), G_CHG);
    endtask

    initial begin
        rst_n = 1'b0; pwr_en = 1'b0; vsel = 2'b00;
        ipk_hit = 1'b0; vout_ok = 1'b0; card_in = 1'b1;
        tick(3);
        // R1: reset state
        chk("R1", "gates in reset", gates(), G_PD);
        chk("R1", "vref in reset", {2'b00, vref_sel}, 4'b0000);
        chk("R1", "overload in reset", {3'b000, overload}, 4'b0000);
        rst_n = 1'b1;
        tick(2);

        // Table walk: R2 code latch, R3 discharge, R4 restart
        for (int i = 0; i < 8; i++) begin
            pwr_en  = VEC[i][6];
            vsel    = VEC[i][5:4];
            card_in = VEC[i][3];
            tick(4);
            chk("R2", $sformatf("vref vec %0d", i), {2'b00, vref_sel}, {2'b00, VEC[i][2:1]});
            chk(VEC[i][0] ? "R3" : "R4", $sformatf("gates vec %0d", i), gates(),
                VEC[i][0] ? G_PD : G_CHG);
        end

        // R5 peak ends charge, R8 dead cycle, R6 transfer length
        enter_charge();
        tick(4);
        ipk_hit = 1'b1; tick(); ipk_hit = 1'b0;
        chk("R8", "dead after peak", gates(), G_OFF);
        tick();
        chk("R5", "transfer after peak", gates(), G_XF);
        tick(XFER - 1);
        chk("R6", "last transfer cycle", gates(), G_XF);
        tick();
        chk("R6", "dead after transfer", gates(), G_OFF);
        tick();
        chk("R6", "charge after transfer", gates(), G_CHG);

        // R7 regulation mid-transfer
        ipk_hit = 1'b1; tick(); ipk_hit = 1'b0; tick();
        tick(5);
        vout_ok = 1'b1; tick();
        chk("R7", "transfer cut at regulation", gates(), G_OFF);
        tick();
        chk("R7", "clamp on", gates(), G_CL);
        tick(10);
        chk("R7", "clamp held", gates(), G_CL);
        vout_ok = 1'b0; tick();
        chk("R8", "dead after clamp", gates(), G_OFF);
        tick();
        chk("R7", "charge after clamp", gates(), G_CHG);

        // R7 regulation on last transfer cycle beats new charge
        ipk_hit = 1'b1; tick(); ipk_hit = 1'b0; tick();
        tick(XFER - 1);
        vout_ok = 1'b1; tick();
        chk("R7", "dead on last-cycle regulation", gates(), G_OFF);
        tick();
        chk("R7", "clamp after last-cycle regulation", gates(), G_CL);
        vout_ok = 1'b0; tick(2);
        chk("R7", "charge after collision", gates(), G_CHG);

        // R9 watchdog expiry, R10 sticky overload
        chk("R9", "no overload yet", {3'b000, overload}, 4'b0000);
        tick(WDOG - 1);
        chk("R9", "still charging at limit", gates(), G_CHG);
        tick();
        chk("R9", "forced dead", gates(), G_OFF);
        chk("R9", "overload set", {3'b000, overload}, 4'b0001);
        tick();
        chk("R9", "transfer after timeout", gates(), G_XF);
        tick(30);
        chk("R10", "overload sticky", {3'b000, overload}, 4'b0001);
        pwr_en = 1'b0; tick();
        chk("R10", "overload cleared", {3'b000, overload}, 4'b0000);
        chk("R2", "vref off with power", {2'b00, vref_sel}, 4'b0000);

        // R9 peak on the final watchdog cycle
        enter_charge();
        tick(WDOG - 1);
        ipk_hit = 1'b1; tick(); ipk_hit = 1'b0;
        chk("R9", "dead on collision", gates(), G_OFF);
        chk("R9", "no overload on collision", {3'b000, overload}, 4'b0000);
        tick();
        chk("R9", "transfer on collision", gates(), G_XF);

        // R3 card removal while clamping
        vout_ok = 1'b1; tick(2);
        chk("R7", "clamp before removal", gates(), G_CL);
        card_in = 1'b0; tick();
        chk("R3", "dead on removal", gates(), G_OFF);
        tick();
        chk("R3", "pull-down on removal", gates(), G_PD);
        tick(5);
        chk("R3", "pull-down held", gates(), G_PD);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule